// File: doc/BRIEF.md
# Scalable 64-bit System Counter

This block produces a 64-bit system count for a set of timers. Each cycle in which the reference tick input is high, an enabled counter moves forward. In plain mode it adds one. In scaled mode it adds a programmable rate in unsigned 8.24 fixed point. A hidden 24-bit fraction accumulator keeps the remainder between ticks, so rates that are not whole numbers, such as 1/16, give an exact average over time.

Software reaches the block through a small word-addressed register port. It can write the control word, program the rate while the counter is stopped, and read or write the count as two 32-bit words. The full count is driven on a dedicated output. That output is a register, so it reflects a tick or a write from the cycle after that event.

Top module: `scnt_top`

## Requirements
- R1: After reset, the count is 0 and the control word reads 0. The scale register reads 0x01000000 (8.24 fixed point, one count per tick). The fraction accumulator is 0.
- R2: While control bit 0 (enable) is 0, the count does not move, however many ticks arrive.
- R3: While enabled with control bit 2 (scaled mode) at 0, each tick adds exactly one to the count. Cycles without a tick leave the count unchanged.
- R4: While enabled in scaled mode, each tick adds the scale value to the 24-bit fraction accumulator. The carry out of the accumulator's top bit goes into the count. A scale of 0x00100000 adds 10 over 160 ticks.
- R5: The fraction survives a change of rate. With a count of 2000 and then the rate set to 1/16, 31996 ticks give 3999 and 4 more ticks give 4000.
- R6: The count low word is at byte offset 0x08 and the high word at 0x0C. A write replaces only that word and clears the fraction accumulator. A count write wins over a tick that arrives in the same cycle.
- R7: The scale register is at offset 0x10. A write to it while enabled is ignored.
- R8: The control word is at offset 0x00 and reads back only bits 0 and 2. Reads of offsets not listed in R6 to R8 return 0.
- R9: A carry out of the low 32 bits reaches the high word. The count output always equals {high word, low word}.
- R10: Scale values above one give whole-plus-fraction steps. 0x02800000 (2.5) adds 2, then 3, then 5 over the next two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference tick, one cycle per count period |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| count_o | output | 64 | Current system count |

## Verification
A tick or a register write is taken at one rising edge, and its effect shows on count_o and in the register read data one edge later. Read data follows the address without a clock, so a read check only changes the address and samples a moment later. The bench drives stimulus on falling edges and samples on the next falling edge, which falls after the single register stage that every result passes through. Long tick runs space the ticks out with idle cycles, so the hold behaviour between ticks is exercised in every run.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
    // Register byte offsets
    localparam int unsigned OFS_CTRL  = 'h00;
    localparam int unsigned OFS_CNTLO = 'h08;
    localparam int unsigned OFS_CNTHI = 'h0C;
    localparam int unsigned OFS_SCALE = 'h10;

    // Control word bit positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_SCL_BIT = 2;
endpackage

// File: rtl/scnt_step.sv
// Computes one scaled step: integer increment and next fraction.
module scnt_step #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24,
    localparam int SCALE_W = INT_W + FRAC_W
) (
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [FRAC_W-1:0]  frac_i,
    input  logic               scaled_i,
    output logic [INT_W:0]     inc_o,
    output logic [FRAC_W-1:0]  frac_o
);
    logic [SCALE_W:0] sum;

    always_comb begin
        sum = {1'b0, scale_i} + {{(SCALE_W+1-FRAC_W){1'b0}}, frac_i};
        if (scaled_i) begin
            inc_o  = sum[SCALE_W:FRAC_W];
            frac_o = sum[FRAC_W-1:0];
        end else begin
            inc_o  = {{INT_W{1'b0}}, 1'b1};
            frac_o = frac_i;
        end
    end
endmodule

// File: rtl/scnt_rdmux.sv
// Register read selection.
module scnt_rdmux #(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter int SCALE_W = 32,
    localparam int CNT_W  = 2 * DW
) (
    input  logic [AW-1:0]      addr_i,
    input  logic               en_i,
    input  logic               scl_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [DW-1:0]      rdata_o
);
    import scnt_pkg::*;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            AW'(OFS_CTRL): begin
                rdata_o[CTRL_EN_BIT]  = en_i;
                rdata_o[CTRL_SCL_BIT] = scl_i;
            end
            AW'(OFS_CNTLO): rdata_o = cnt_i[DW-1:0];
            AW'(OFS_CNTHI): rdata_o = cnt_i[CNT_W-1:DW];
            AW'(OFS_SCALE): rdata_o = DW'(scale_i);
            default:        rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/scnt_top.sv
// Scalable 64-bit system counter.
module scnt_top #(
    parameter int DW     = 32,
    parameter int AW     = 5,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24,
    localparam int CNT_W   = 2 * DW,
    localparam int SCALE_W = INT_W + FRAC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [CNT_W-1:0] count_o
);
    import scnt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAC_W-1:0]  frac;
        logic [SCALE_W-1:0] scale;
        logic               en;
        logic               scl;
    } state_t;

    localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

    state_t st_d, st_q;

    logic [INT_W:0]    step_inc;
    logic [FRAC_W-1:0] step_frac;

    scnt_step #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W)
    ) step_i (
        .scale_i (st_q.scale),
        .frac_i  (st_q.frac),
        .scaled_i(st_q.scl),
        .inc_o   (step_inc),
        .frac_o  (step_frac)
    );

    scnt_rdmux #(
        .DW     (DW),
        .AW     (AW),
        .SCALE_W(SCALE_W)
    ) rdmux_i (
        .addr_i (addr_i),
        .en_i   (st_q.en),
        .scl_i  (st_q.scl),
        .cnt_i  (st_q.cnt),
        .scale_i(st_q.scale),
        .rdata_o(rdata_o)
    );

    always_comb begin
        st_d = st_q;
        if (tick_i && st_q.en) begin
            st_d.cnt  = st_q.cnt + CNT_W'(step_inc);
            st_d.frac = step_frac;
        end
        if (wr_i) begin
            case (addr_i)
                AW'(OFS_CTRL): begin
                    st_d.en  = wdata_i[CTRL_EN_BIT];
                    st_d.scl = wdata_i[CTRL_SCL_BIT];
                end
                AW'(OFS_CNTLO): begin
                    st_d.cnt          = st_q.cnt;
                    st_d.cnt[DW-1:0]  = wdata_i;
                    st_d.frac         = '0;
                end
                AW'(OFS_CNTHI): begin
                    st_d.cnt            = st_q.cnt;
                    st_d.cnt[CNT_W-1:DW] = wdata_i;
                    st_d.frac           = '0;
                end
                AW'(OFS_SCALE): begin
                    if (!st_q.en) begin
                        st_d.scale = wdata_i[SCALE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.frac  <= '0;
            st_q.scale <= SCALE_ONE;
            st_q.en    <= 1'b0;
            st_q.scl   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/scnt_chk.sv
// Property checker for scnt_top.
module scnt_chk #(
    parameter int DW     = 32,
    parameter int AW     = 5,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24,
    localparam int CNT_W   = 2 * DW,
    localparam int SCALE_W = INT_W + FRAC_W
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               tick_i,
    input logic               wr_i,
    input logic [AW-1:0]      addr_i,
    input logic [DW-1:0]      rdata_o,
    input logic [CNT_W-1:0]   count_o,
    input logic               en,
    input logic               scl,
    input logic [FRAC_W-1:0]  frac,
    input logic [SCALE_W-1:0] scale
);
    import scnt_pkg::*;

    logic cnt_wr, known_addr;
    assign cnt_wr = wr_i && (addr_i == AW'(OFS_CNTLO) || addr_i == AW'(OFS_CNTHI));
    assign known_addr = (addr_i == AW'(OFS_CTRL)) || (addr_i == AW'(OFS_CNTLO)) ||
                        (addr_i == AW'(OFS_CNTHI)) || (addr_i == AW'(OFS_SCALE));

    // R2
    disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !cnt_wr) |=> $stable(count_o));

    // R3
    unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && !scl && tick_i && !cnt_wr) |=> (count_o == $past(count_o) + 1'b1));

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !cnt_wr) |=> $stable(count_o));

    // R4
    scaled_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && scl && tick_i && !cnt_wr) |=> ((count_o - $past(count_o)) <= CNT_W'(1 << INT_W)));

    // R6
    write_clears_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> (frac == '0));

    // R7
    scale_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en |=> $stable(scale));

    // R8
    undef_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !known_addr |-> (rdata_o == '0));
endmodule

bind scnt_top scnt_chk #(
    .DW    (DW),
    .AW    (AW),
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .rdata_o(rdata_o),
    .count_o(count_o),
    .en     (st_q.en),
    .scl    (st_q.scl),
    .frac   (st_q.frac),
    .scale  (st_q.scale)
);

// File: tb/scnt_top_tb_top.sv
`timescale 1ns/1ps
module scnt_top_tb_top;
    localparam int DW = 32;
    localparam int AW = 5;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RUN = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;

    localparam logic [AW-1:0] A_CTRL = 5'h00;
    localparam logic [AW-1:0] A_LO   = 5'h08;
    localparam logic [AW-1:0] A_HI   = 5'h0C;
    localparam logic [AW-1:0] A_SCL  = 5'h10;

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [31:0]   data;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{OP_RUN, A_CTRL, 32'd100,        8'd2},  // R2 disabled
        '{OP_RD,  A_LO,   32'd0,          8'd2},
        '{OP_RD,  A_HI,   32'd0,          8'd2},
        '{OP_WR,  A_CTRL, 32'd1,          8'd3},
        '{OP_RUN, A_CTRL, 32'd100,        8'd3},
        '{OP_RD,  A_LO,   32'd100,        8'd3},  // R3
        '{OP_RD,  A_HI,   32'd0,          8'd3},
        '{OP_WR,  A_CTRL, 32'd0,          8'd4},
        '{OP_WR,  A_SCL,  32'h00100000,   8'd4},
        '{OP_WR,  A_CTRL, 32'd5,          8'd4},
        '{OP_RD,  A_CTRL, 32'd5,          8'd8},  // R8
        '{OP_RUN, A_CTRL, 32'd160,        8'd4},
        '{OP_RD,  A_LO,   32'd110,        8'd4},  // R4
        '{OP_RD,  A_SCL,  32'h00100000,   8'd7},  // R7
        '{OP_WR,  A_CTRL, 32'd0,          8'd5},
        '{OP_WR,  A_LO,   32'd0,          8'd5},
        '{OP_WR,  A_HI,   32'd0,          8'd5},
        '{OP_WR,  A_CTRL, 32'd1,          8'd5},
        '{OP_RUN, A_CTRL, 32'd2000,       8'd5},
        '{OP_RD,  A_LO,   32'd2000,       8'd5},  // R5
        '{OP_WR,  A_CTRL, 32'd0,          8'd5},
        '{OP_WR,  A_CTRL, 32'd5,          8'd5},
        '{OP_RUN, A_CTRL, 32'd31996,      8'd5},
        '{OP_RD,  A_LO,   32'd3999,       8'd5},
        '{OP_RUN, A_CTRL, 32'd4,          8'd5},
        '{OP_RD,  A_LO,   32'd4000,       8'd5},
        '{OP_WR,  A_CTRL, 32'd0,          8'd10},
        '{OP_WR,  A_SCL,  32'h02800000,   8'd10},
        '{OP_WR,  A_LO,   32'd0,          8'd10},
        '{OP_WR,  A_CTRL, 32'd5,          8'd10},
        '{OP_RUN, A_CTRL, 32'd1,          8'd10},
        '{OP_RD,  A_LO,   32'd2,          8'd10}, // R10
        '{OP_RUN, A_CTRL, 32'd1,          8'd10},
        '{OP_RD,  A_LO,   32'd5,          8'd10},
        '{OP_RUN, A_CTRL, 32'd2,          8'd10},
        '{OP_RD,  A_LO,   32'd10,         8'd10},
        '{OP_WR,  A_CTRL, 32'hFF,         8'd8},
        '{OP_RD,  A_CTRL, 32'd5,          8'd8},  // R8
        '{OP_WR,  A_CTRL, 32'd0,          8'd8}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic [2*DW-1:0] count;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    scnt_top dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .tick_i (tick),
        .wr_i   (wr),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .count_o(count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, {32'd0, rdata}, {32'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                OP_WR:  reg_wr(VECS[v].addr, VECS[v].data);
                OP_RUN: run_ticks(int'(VECS[v].data));
                default: rd_chk($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].addr, VECS[v].data);
            endcase
        end

        // R1: reset state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 count_o", count, 64'd0);
        rd_chk("R1 ctrl", A_CTRL, 32'd0);
        rd_chk("R1 scale", A_SCL, 32'h01000000);
        rd_chk("R1 lo", A_LO, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: count write clears the fraction
        reg_wr(A_SCL, 32'h00100000);
        reg_wr(A_CTRL, 32'd5);
        run_ticks(8);
        rd_chk("R6 half", A_LO, 32'd0);
        reg_wr(A_LO, 32'd0);
        run_ticks(8);
        rd_chk("R6 frac cleared", A_LO, 32'd0);
        run_ticks(8);
        rd_chk("R6 frac resumed", A_LO, 32'd1);

        // R6: write wins over same-cycle tick
        reg_wr(A_CTRL, 32'd0);
        reg_wr(A_LO, 32'd7);
        reg_wr(A_CTRL, 32'd1);
        @(negedge clk);
        wr = 1'b1; addr = A_LO; wdata = 32'h55; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        rd_chk("R6 write wins", A_LO, 32'h55);
        run_ticks(1);
        rd_chk("R3 after write", A_LO, 32'h56);

        // R7: scale write ignored while enabled
        reg_wr(A_SCL, 32'h03000000);
        rd_chk("R7 scale locked", A_SCL, 32'h00100000);
        reg_wr(A_CTRL, 32'd5);
        run_ticks(16);
        rd_chk("R7 rate unchanged", A_LO, 32'h57);

        // R9: carry into the high word
        reg_wr(A_CTRL, 32'd0);
        reg_wr(A_LO, 32'hFFFFFFFF);
        reg_wr(A_HI, 32'd0);
        reg_wr(A_CTRL, 32'd1);
        run_ticks(1);
        rd_chk("R9 lo", A_LO, 32'd0);
        rd_chk("R9 hi", A_HI, 32'd1);
        chk("R9 count_o", count, 64'h1_0000_0000);

        // R8: undefined offsets
        rd_chk("R8 off04", 5'h04, 32'd0);
        rd_chk("R8 off14", 5'h14, 32'd0);
        rd_chk("R8 off1C", 5'h1C, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule